// File: doc/BRIEF.md
# Transceiver Link Bring-Up Sequencer

This block is the control engine that takes a serial transceiver receiver from reset to a working link. It drives the receiver only through a request/acknowledge command channel. It issues one command code at a time and waits for the acknowledge. For status polls it also reads a done bit that comes back with the acknowledge. The analog front end, the adaptation engines and the register addresses sit behind that channel and are outside this block.

A start request latches the temperature mode. The sequencer first calibrates with the internal loopback path switched on. It then switches the loopback off and adapts against the real channel, and waits for clock-data-recovery lock. In dynamic temperature mode it finishes by starting continuous adaptation; static mode stops without it. Once the link is up, the sequencer handles four events: a channel change (re-adaptation), an error-counter read (with a freeze of continuous adaptation when needed), lock loss or a high error rate (analog reset and full restart), and timeouts (counted retries, ending in a sticky fault).

Top module: `xcvr_bringup_seq`

## Requirements
- R1: After reset, cmdValid, linkUp, busy, fault and errReadDone are 0. In the idle state chanChanged and errReadReq issue no command; only startReq begins a sequence.
- R2: Once cmdValid rises it stays high until the cycle in which cmdAck is high, and cmdCode does not change during that time. A new command is issued only when none is pending.
- R3: Command codes are: 1 loopback on, 2 loopback off, 3 start initial adaptation, 4 poll adaptation done, 5 start continuous adaptation, 6 stop continuous adaptation, 7 read error counter, 8 analog reset. A bring-up issues 1, 3, 4, then 2, 3, 4, in that order.
- R4: Code 4 is reissued after every acknowledge that returns ackDone=0. The sequence moves on only after an acknowledge of code 4 with ackDone=1.
- R5: In static mode (dynMode=0 at start) bring-up ends after the mission-mode poll and the lock wait, with no code 5. In dynamic mode code 5 follows, issued only after the lock wait that follows a completed adaptation.
- R6: linkUp is high only when the final state has been reached and cdrLock is high. busy is high in every state other than idle, final and fault.
- R7: A chanChanged pulse in the final state gives 6, 3, 4, 5 in dynamic mode and 3, 4 in static mode, and then the final state again.
- R8: An errReadReq pulse in the final state gives 6, 7, 5 in dynamic mode with softChecker=0. It gives 7 alone in static mode or with softChecker=1. errReadDone pulses for one cycle, the cycle after code 7 is acknowledged.
- R9: Lock loss or highErr in the final state issues code 8, then the full sequence again from code 1.
- R10: A failure is either a code 4 acknowledge with ackDone=0 arriving once timeoutLimit cycles have passed in the poll state, or a lock wait that lasts timeoutLimit cycles without cdrLock. A failure issues code 8 and restarts from code 1.
- R11: The third consecutive failure sets fault, which stays high with no command issued and busy low until startReq. startReq clears fault and starts over. Reaching the final state clears the failure count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a bring-up from idle or fault |
| dynMode | input | 1 | 1 selects dynamic temperature mode; sampled at start |
| softChecker | input | 1 | External soft pattern checker in use; error reads skip the freeze |
| chanChanged | input | 1 | Connected channel changed event |
| cdrLock | input | 1 | Receiver clock-data-recovery lock |
| highErr | input | 1 | High bit-error-rate flag |
| errReadReq | input | 1 | Request to read the hardware error counter |
| timeoutLimit | input | TMO_W | Timeout in clock cycles for polls and the lock wait |
| cmdAck | input | 1 | Acknowledge of the pending command |
| ackDone | input | 1 | Done bit returned with a poll acknowledge |
| cmdValid | output | 1 | Command pending |
| cmdCode | output | 4 | Code of the pending command |
| linkUp | output | 1 | Link is up |
| busy | output | 1 | Sequence in progress |
| fault | output | 1 | Sticky fault after repeated failures |
| errReadDone | output | 1 | One-cycle pulse when an error-counter read completes |

## Verification
Bring-up is run in both temperature modes, with polls that report done at once and polls that report not-done one or two times first. Comparing the logged command streams separates mode handling from the poll-repeat logic. In the final state, channel changes and error reads are applied in each mode and with the soft-checker input both ways; this shows whether the freeze and resume wrap only the case that needs it. Lock loss, the error flag and a held-off lock are then applied. These separate an uncounted restart, a counted retry and the sticky fault with its release by a new start.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE       = 4'd0,
    CMD_LPBK_ON    = 4'd1,
    CMD_LPBK_OFF   = 4'd2,
    CMD_INIT_ADAPT = 4'd3,
    CMD_POLL_DONE  = 4'd4,
    CMD_CONT_START = 4'd5,
    CMD_CONT_STOP  = 4'd6,
    CMD_ERR_READ   = 4'd7,
    CMD_ANA_RESET  = 4'd8
  } cmd_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic issue;
    cmd_e code;
    logic tmrClr;
    logic retryInc;
    logic retryClr;
    logic faultSet;
    logic faultClr;
  } ctlStrb_t;

endpackage

// File: rtl/bringup_dp.sv
module bringup_dp
  import bringup_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int MAX_RETRY = 3,
  parameter int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strb,
  input  logic               cmdAck,
  input  logic [TMO_W-1:0]   timeoutLimit,
  output logic               cmdValid,
  output logic [CMD_W-1:0]   cmdCode,
  output logic               ackSeen,
  output logic               tmo,
  output logic [RETRY_W-1:0] retryCnt,
  output logic               fault
);

  logic [TMO_W-1:0] tmrCnt;

  // Command holding register: valid until acknowledged
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdCode  <= '0;
    end else if (strb.issue) begin
      cmdValid <= 1'b1;
      cmdCode  <= strb.code;
    end else if (cmdAck) begin
      cmdValid <= 1'b0;
    end
  end

  assign ackSeen = cmdValid && cmdAck;

  // Per-state timer, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strb.tmrClr) begin
      tmrCnt <= '0;
    end else if (tmrCnt != '1) begin
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  assign tmo = (tmrCnt >= timeoutLimit);

  // Consecutive failure counter
  always_ff @(posedge clk) begin
    if (!rstN || strb.retryClr) begin
      retryCnt <= '0;
    end else if (strb.retryInc && retryCnt != RETRY_W'(MAX_RETRY)) begin
      retryCnt <= retryCnt + 1'b1;
    end
  end

  // Sticky fault flag
  always_ff @(posedge clk) begin
    if (!rstN || strb.faultClr) begin
      fault <= 1'b0;
    end else if (strb.faultSet) begin
      fault <= 1'b1;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> cmdValid); // R2
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> $stable(cmdCode)); // R2
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !strb.faultClr) |=> fault); // R11
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RETRY_W'(MAX_RETRY)); // R11

endmodule

// File: rtl/bringup_ctrl.sv
module bringup_ctrl
  import bringup_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               dynMode,
  input  logic               softChecker,
  input  logic               chanChanged,
  input  logic               cdrLock,
  input  logic               highErr,
  input  logic               errReadReq,
  input  logic               ackDone,
  input  logic               cmdValid,
  input  logic [CMD_W-1:0]   cmdCode,
  input  logic               ackSeen,
  input  logic               tmo,
  input  logic [RETRY_W-1:0] retryCnt,
  output ctlStrb_t           strb,
  output logic               linkUp,
  output logic               busy,
  output logic               errReadDone
);

  typedef enum logic [3:0] {
    S_IDLE, S_LPON, S_INIT_LB, S_POLL_LB, S_LPOFF, S_INIT_MS, S_POLL_MS,
    S_WAIT_LOCK, S_CONT_ON, S_RUN, S_CONT_OFF, S_FRZ, S_ERRRD, S_RESUME,
    S_ARST, S_FAULT
  } state_e;

  state_e state, stateN;
  logic   dynQ, dynN, frozenQ, frozenN;
  logic   reissue, failEv;
  cmd_e   cmdN;

  function automatic cmd_e cmdFor(input state_e s);
    case (s)
      S_LPON:               return CMD_LPBK_ON;
      S_LPOFF:              return CMD_LPBK_OFF;
      S_INIT_LB, S_INIT_MS: return CMD_INIT_ADAPT;
      S_POLL_LB, S_POLL_MS: return CMD_POLL_DONE;
      S_CONT_ON, S_RESUME:  return CMD_CONT_START;
      S_CONT_OFF, S_FRZ:    return CMD_CONT_STOP;
      S_ERRRD:              return CMD_ERR_READ;
      S_ARST:               return CMD_ANA_RESET;
      default:              return CMD_NONE;
    endcase
  endfunction

  always_comb begin
    stateN  = state;
    dynN    = dynQ;
    frozenN = frozenQ;
    reissue = 1'b0;
    failEv  = 1'b0;
    strb    = '0;
    unique case (state)
      S_IDLE, S_FAULT: begin
        if (startReq) begin
          stateN        = S_LPON;
          dynN          = dynMode;
          strb.retryClr = 1'b1;
          strb.faultClr = 1'b1;
        end
      end
      S_LPON:    if (ackSeen) stateN = S_INIT_LB;
      S_INIT_LB: if (ackSeen) stateN = S_POLL_LB;
      S_LPOFF:   if (ackSeen) stateN = S_INIT_MS;
      S_INIT_MS: if (ackSeen) stateN = S_POLL_MS;
      S_POLL_LB, S_POLL_MS: begin
        if (ackSeen) begin
          if (ackDone)  stateN = (state == S_POLL_LB) ? S_LPOFF : S_WAIT_LOCK;
          else if (tmo) failEv = 1'b1;
          else          reissue = 1'b1;
        end
      end
      S_WAIT_LOCK: begin
        if (cdrLock) begin
          stateN = dynQ ? S_CONT_ON : S_RUN;
          if (!dynQ) strb.retryClr = 1'b1;
        end else if (tmo) begin
          failEv = 1'b1;
        end
      end
      S_CONT_ON: begin
        if (ackSeen) begin
          stateN        = S_RUN;
          strb.retryClr = 1'b1;
        end
      end
      S_RUN: begin
        if (!cdrLock || highErr) begin
          stateN = S_ARST;
        end else if (chanChanged) begin
          stateN = dynQ ? S_CONT_OFF : S_INIT_MS;
        end else if (errReadReq) begin
          frozenN = dynQ && !softChecker;
          stateN  = frozenN ? S_FRZ : S_ERRRD;
        end
      end
      S_CONT_OFF: if (ackSeen) stateN = S_INIT_MS;
      S_FRZ:      if (ackSeen) stateN = S_ERRRD;
      S_ERRRD:    if (ackSeen) stateN = frozenQ ? S_RESUME : S_RUN;
      S_RESUME:   if (ackSeen) stateN = S_RUN;
      S_ARST:     if (ackSeen) stateN = S_LPON;
      default:    stateN = S_IDLE;
    endcase

    if (failEv) begin
      strb.retryInc = 1'b1;
      if (retryCnt == RETRY_W'(MAX_RETRY - 1)) begin
        stateN        = S_FAULT;
        strb.faultSet = 1'b1;
      end else begin
        stateN = S_ARST;
      end
    end

    cmdN        = cmdFor(stateN);
    strb.code   = cmdN;
    strb.issue  = ((stateN != state) || reissue) && (cmdN != CMD_NONE);
    strb.tmrClr = (stateN != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      dynQ        <= 1'b0;
      frozenQ     <= 1'b0;
      errReadDone <= 1'b0;
    end else begin
      state       <= stateN;
      dynQ        <= dynN;
      frozenQ     <= frozenN;
      errReadDone <= (state == S_ERRRD) && ackSeen;
    end
  end

  assign linkUp = (state == S_RUN) && cdrLock;
  assign busy   = (state != S_IDLE) && (state != S_RUN) && (state != S_FAULT);

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (!cmdValid || ackSeen)); // R2
  AST_CONT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.code == CMD_CONT_START) |-> (state == S_WAIT_LOCK || state == S_ERRRD)); // R5
  AST_RESET_ON_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && (!cdrLock || highErr)) |=> (cmdValid && cmdCode == CMD_ANA_RESET)); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FAULT) |-> !cmdValid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !startReq) |=> !cmdValid); // R1

endmodule

// File: rtl/xcvr_bringup_seq.sv
module xcvr_bringup_seq
  import bringup_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             dynMode,
  input  logic             softChecker,
  input  logic             chanChanged,
  input  logic             cdrLock,
  input  logic             highErr,
  input  logic             errReadReq,
  input  logic [TMO_W-1:0] timeoutLimit,
  input  logic             cmdAck,
  input  logic             ackDone,
  output logic             cmdValid,
  output logic [3:0]       cmdCode,
  output logic             linkUp,
  output logic             busy,
  output logic             fault,
  output logic             errReadDone
);

  localparam int RETRY_W = $clog2(MAX_RETRY + 1);

  ctlStrb_t           strb;
  logic               ackSeen;
  logic               tmo;
  logic [RETRY_W-1:0] retryCnt;

  bringup_ctrl #(.MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dynMode(dynMode),
    .softChecker(softChecker), .chanChanged(chanChanged), .cdrLock(cdrLock),
    .highErr(highErr), .errReadReq(errReadReq), .ackDone(ackDone),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .ackSeen(ackSeen), .tmo(tmo),
    .retryCnt(retryCnt), .strb(strb), .linkUp(linkUp), .busy(busy),
    .errReadDone(errReadDone)
  );

  bringup_dp #(.TMO_W(TMO_W), .MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAck(cmdAck),
    .timeoutLimit(timeoutLimit), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .ackSeen(ackSeen), .tmo(tmo), .retryCnt(retryCnt), .fault(fault)
  );

endmodule

// File: tb/xcvr_bringup_seq_tb.sv
module xcvr_bringup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ACK_DLY    = 2;
  // Row: [63] dyn, [62:60] not-done polls, [59:56] length, [47:0] codes (first in [3:0])
  localparam logic [63:0] VEC [4] = '{
    {1'b0, 3'd0, 4'd6,  8'h00, 48'h000000432431},
    {1'b1, 3'd0, 4'd7,  8'h00, 48'h000005432431},
    {1'b0, 3'd2, 4'd10, 8'h00, 48'h004443244431},
    {1'b1, 3'd1, 4'd9,  8'h00, 48'h000544324431}
  };

  logic clk = 0, rstN = 0;
  logic startReq = 0, dynMode = 0, softChecker = 0, chanChanged = 0;
  logic cdrLock = 0, highErr = 0, errReadReq = 0, cmdAck = 0, ackDone = 0;
  logic [15:0] timeoutLimit = 16'd200;
  logic cmdValid, linkUp, busy, fault, errReadDone;
  logic [3:0] cmdCode;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [3:0] cmdLog [0:63];
  int logN = 0, pollNeed = 0, pollSeen = 0, stabErr = 0, rdPulses = 0;

  xcvr_bringup_seq dut_i (.*);

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // Command responder and handshake monitor
  initial begin
    int wcnt = 0;
    logic pv = 0, pa = 0;
    logic [3:0] pc = 0;
    forever begin
      @(negedge clk);
      if (cmdValid && pv && !pa && cmdCode != pc) stabErr++;
      pv = cmdValid; pc = cmdCode;
      cmdAck = 0; ackDone = 0;
      if (errReadDone) rdPulses++;
      if (!rstN) begin
        wcnt = 0; pollSeen = 0;
      end else if (cmdValid) begin
        if (wcnt == ACK_DLY) begin
          cmdAck = 1; wcnt = 0;
          if (logN < 64) cmdLog[logN] = cmdCode;
          logN++;
          if (cmdCode == 4'd4) begin
            ackDone = (pollSeen >= pollNeed);
            pollSeen++;
          end else pollSeen = 0;
        end else wcnt++;
      end else wcnt = 0;
      pa = cmdAck;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chkSeq(input string req, input logic [47:0] exp, input int len);
    logic [47:0] got = '0;
    for (int i = 0; i < len && i < 12; i++) got[i*4 +: 4] = cmdLog[i];
    chk({req, " length"}, 64'(logN), 64'(len));
    chk({req, " codes"}, 64'(got), 64'(exp));
  endtask

  task automatic doReset();
    rstN = 0; startReq = 0; chanChanged = 0; errReadReq = 0; highErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    logN = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; @(negedge clk); sig = 0;
  endtask

  task automatic waitLink(input int lim);
    for (int i = 0; i < lim && !linkUp; i++) @(negedge clk);
  endtask

  task automatic bringUp(input logic dyn);
    dynMode = dyn; cdrLock = 1; pollNeed = 0;
    pulse(startReq);
    waitLink(3000);
    logN = 0;
  endtask

  initial begin
    doReset();
    @(negedge clk); #1;
    chk("R1 reset outputs", {cmdValid, linkUp, busy, fault, errReadDone}, 0);
    pulse(chanChanged); pulse(errReadReq);
    repeat (5) @(negedge clk);
    chk("R1 idle ignores events", {cmdValid, busy, 27'(logN)}, 0);

    // Table of bring-up scenarios
    for (int r = 0; r < 4; r++) begin
      doReset();
      dynMode = VEC[r][63]; pollNeed = int'(VEC[r][62:60]); cdrLock = 1;
      pulse(startReq);
      if (r == 0) chk("R6 busy during bring-up", {busy, linkUp}, 2'b10);
      waitLink(3000);
      chk("R6 link up at end", {linkUp, busy}, 2'b10);
      chkSeq("R3 R4 R5 bring-up sequence", VEC[r][47:0], int'(VEC[r][59:56]));
    end

    // Dynamic mode events
    doReset(); bringUp(1);
    pulse(chanChanged); waitLink(3000);
    chkSeq("R7 dyn channel change", 48'h5436, 4);
    logN = 0; rdPulses = 0; softChecker = 0;
    pulse(errReadReq); waitLink(3000); @(negedge clk);
    chkSeq("R8 dyn hard read", 48'h576, 3);
    chk("R8 read done pulse", 64'(rdPulses), 1);
    logN = 0; softChecker = 1;
    pulse(errReadReq); waitLink(3000);
    chkSeq("R8 soft checker read", 48'h7, 1);
    softChecker = 0; logN = 0;
    pulse(highErr); waitLink(3000);
    chkSeq("R9 high error restart", 48'h54324318, 8);

    // Static mode events
    doReset(); bringUp(0);
    pulse(chanChanged); waitLink(3000);
    chkSeq("R7 static channel change", 48'h43, 2);
    logN = 0;
    pulse(errReadReq); waitLink(3000);
    chkSeq("R8 static read", 48'h7, 1);
    logN = 0;
    cdrLock = 0; #1;
    chk("R6 link drops with lock", 64'(linkUp), 0);
    @(negedge clk); cdrLock = 1;
    waitLink(3000);
    chkSeq("R9 lock loss restart", 48'h4324318, 7);

    // Lock wait timeouts to fault
    doReset(); timeoutLimit = 16'd20; cdrLock = 0; dynMode = 0; pollNeed = 0;
    pulse(startReq);
    for (int i = 0; i < 3000 && !fault; i++) @(negedge clk);
    chk("R10 R11 failures before fault", 64'(logN), 20);
    chk("R10 reset after timeout", {cmdLog[6], cmdLog[13], cmdLog[19]}, 12'h884);
    chk("R11 fault state", {fault, busy, cmdValid}, 3'b100);
    repeat (50) @(negedge clk);
    chk("R11 fault sticky and quiet", {fault, cmdValid, 26'(logN)}, {2'b10, 26'd20});
    cdrLock = 1; logN = 0;
    pulse(startReq);
    chk("R11 start clears fault", 64'(fault), 0);
    waitLink(3000);
    chk("R11 recovery link", 64'(linkUp), 1);
    chk("R2 code stable while pending", 64'(stabErr), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule